// File: doc/BRIEF.md
# Packing Vector Configuration Generator

This block turns a description of the serial word geometry (bits per protocol word, words per FIFO entry, and bit order) into the slice descriptors that a FIFO packer or unpacker uses to move bits between FIFO entries and the serial shifter. Each descriptor covers at most one byte of a protocol word. It gives the starting bit position, the traversal direction, the slice length and an end-of-entry flag. Up to four descriptors are produced. They are folded pairwise into two 32-bit configuration words.

A request is presented with a one-cycle `start` strobe. One cycle later the block raises `done` for one cycle and updates its registered outputs. Two select inputs choose whether the transmit configuration bank, the receive bank, or both are loaded. A request that needs no descriptors, or more than four, is flagged as invalid and loads nothing. A two-bit lane granularity code is produced alongside the vectors.

Top module: `pack_cfg_gen`

## Requirements
- R1: Each 10-bit descriptor holds the start bit position in bits [9:5], the direction (1 = MSB first) in bit 4, the slice length minus one in bits [3:1], and the end-of-entry flag in bit 0.
- R2: The descriptor count is ceil(bits_per_word/8) × words_per_entry. A count of 0 or above 4 sets `invalid` and leaves `tx_cfg*`, `rx_cfg*` and `gran_code` unchanged, with no write strobe.
- R3: The length field of a descriptor is min(bits left in the current word, 8) − 1.
- R4: The first word starts at bits_per_word−1 when MSB first and at 0 otherwise. Within a word each later slice starts 8 lower (MSB first) or 8 higher (LSB first). Word n starts at n × 8 × ceil(bits_per_word/8) plus the first word's start.
- R5: Only the last used descriptor has the end-of-entry flag. Every used descriptor carries the direction bit equal to `msb_first`. Unused descriptors are all zero.
- R6: Configuration word 0 is descriptor0 | descriptor1<<10 and configuration word 1 is descriptor2 | descriptor3<<10, with bits [31:20] zero.
- R7: `gran_code` takes bits_per_word/16 (0 = four 8-bit lanes, 1 = two 16-bit lanes, 2 = one 32-bit lane). It is loaded, with a one-cycle `gran_we`, only for a valid request where words_per_entry is nonzero or bits_per_word is 32. Otherwise it holds.
- R8: For a valid request, `tx_sel` loads the transmit bank and pulses `tx_we`, and `rx_sel` does the same for the receive bank with `rx_we`. A bank that is not selected keeps its value.
- R9: `done` is high exactly in the cycle after a `start` cycle. All outputs for that request are valid while `done` is high, and every write strobe coincides with `done`.
- R10: After synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe; geometry inputs sampled with it |
| bits_per_word | input | 6 | Protocol word width in bits |
| words_per_entry | input | 3 | Protocol words per FIFO entry |
| msb_first | input | 1 | Bit order: 1 = MSB first |
| tx_sel | input | 1 | Load the transmit configuration bank |
| rx_sel | input | 1 | Load the receive configuration bank |
| done | output | 1 | Request completed (one cycle) |
| invalid | output | 1 | Last request needed 0 or more than 4 descriptors |
| tx_we | output | 1 | Transmit bank was loaded this cycle |
| rx_we | output | 1 | Receive bank was loaded this cycle |
| gran_we | output | 1 | Granularity code was loaded this cycle |
| tx_cfg0 | output | 32 | Transmit descriptors 0 and 1 |
| tx_cfg1 | output | 32 | Transmit descriptors 2 and 3 |
| rx_cfg0 | output | 32 | Receive descriptors 0 and 1 |
| rx_cfg1 | output | 32 | Receive descriptors 2 and 3 |
| gran_code | output | 2 | Lane granularity code |

## Verification
The descriptors are built one per slot from the word geometry and registered one cycle after the strobe. A wrong slot index, remainder or base offset therefore shows up in the configuration word on the `done` cycle of the very request that exercises it. A wrong end-of-entry or validity decision shows up there too, as a missing or doubled stop flag or as a write strobe on an invalid request. A bank enable or hold fault is only visible when a later request leaves that bank unselected, so the sweep alternates the bank selects and compares held values on every completion.

// File: rtl/pack_cfg_pkg.sv
package pack_cfg_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BYTE_LOG  = $clog2(BYTE_BITS);
    localparam int NUM_VEC   = 4;
    localparam int START_W   = 5;
    localparam int LEN_W     = 3;
    localparam int VEC_W     = START_W + 1 + LEN_W + 1;
    localparam int CFG_W     = 32;
    localparam int NUM_CFG   = NUM_VEC / 2;
    localparam int BPW_W     = 6;
    localparam int WPE_W     = 3;
    localparam int GRAN_W    = 2;
    localparam int GRAN_DIV  = 16;
    localparam int GRAN_SH   = $clog2(GRAN_DIV);
    localparam int NUM_BANKS = 2;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic               dir;
        logic [LEN_W-1:0]   len_m1;
        logic               stop;
    } slice_t;

    typedef enum logic [GRAN_W-1:0] {
        GRAN_LANES8  = 2'd0,
        GRAN_LANES16 = 2'd1,
        GRAN_LANES32 = 2'd2,
        GRAN_RSVD    = 2'd3
    } gran_e;

    typedef struct packed {
        logic  valid;
        logic  gran_ok;
        gran_e gran;
    } geom_t;

    function automatic logic [CFG_W-1:0] join_pair(slice_t lo, slice_t hi);
        logic [CFG_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]       = lo;
        w[2*VEC_W-1:VEC_W] = hi;
        return w;
    endfunction

endpackage

// File: rtl/pack_geom.sv
module pack_geom
    import pack_cfg_pkg::*;
#(
    parameter int BW    = BPW_W,
    parameter int WW    = WPE_W,
    parameter int NV    = NUM_VEC,
    parameter int FULLW = CFG_W,
    localparam int BPB_W = BW - 2,
    localparam int CNT_W = BPB_W + WW
) (
    input  logic [BW-1:0]    bpw,
    input  logic [WW-1:0]    wpe,
    output logic [BPB_W-1:0] bytes_per_word,
    output logic [CNT_W-1:0] vec_count,
    output geom_t            geom
);

    logic [BW:0] rounded;

    always_comb begin
        rounded        = {1'b0, bpw} + (BW+1)'(BYTE_BITS - 1);
        bytes_per_word = rounded[BW:BYTE_LOG];
        vec_count      = CNT_W'(bytes_per_word) * CNT_W'(wpe);
        geom.valid     = (vec_count != '0) && (vec_count <= CNT_W'(NV));
        geom.gran_ok   = geom.valid && ((wpe != '0) || (bpw == BW'(FULLW)));
        geom.gran      = gran_e'(GRAN_W'(bpw >> GRAN_SH));
    end

endmodule

// File: rtl/pack_slice.sv
module pack_slice
    import pack_cfg_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int BW    = BPW_W,
    parameter int BPB_W = BPW_W - 2,
    parameter int CNT_W = BPB_W + WPE_W
) (
    input  logic [BW-1:0]    bpw,
    input  logic [BPB_W-1:0] bytes_per_word,
    input  logic [CNT_W-1:0] vec_count,
    input  logic             msb_first,
    output slice_t           slice
);

    logic [BPB_W-1:0]   divisor;
    logic [BPB_W-1:0]   byte_in_word;
    logic [START_W-1:0] word_base;
    logic [START_W-1:0] byte_off;
    logic [START_W-1:0] first_bit;
    logic [START_W-1:0] pos;
    logic [BW-1:0]      remain;
    logic               used;

    always_comb begin
        divisor      = (bytes_per_word == '0) ? BPB_W'(1) : bytes_per_word;
        byte_in_word = BPB_W'(IDX) % divisor;
        // slot index minus byte offset = first slot of this word
        word_base    = START_W'(BPB_W'(IDX) - byte_in_word) << BYTE_LOG;
        byte_off     = START_W'(byte_in_word) << BYTE_LOG;
        first_bit    = msb_first ? START_W'(bpw - BW'(1)) : '0;
        pos          = msb_first ? (word_base + first_bit - byte_off)
                                 : (word_base + byte_off);
        remain       = bpw - (BW'(byte_in_word) << BYTE_LOG);
        used         = CNT_W'(IDX) < vec_count;

        slice        = '0;
        if (used) begin
            slice.start  = pos;
            slice.dir    = msb_first;
            slice.len_m1 = (remain >= BW'(BYTE_BITS)) ? LEN_W'(BYTE_BITS - 1)
                                                      : LEN_W'(remain - BW'(1));
            slice.stop   = (CNT_W'(IDX + 1) == vec_count);
        end
    end

endmodule

// File: rtl/pack_bank.sv
module pack_bank
    import pack_cfg_pkg::*;
#(
    parameter int WORDS = NUM_CFG,
    parameter int WIDTH = CFG_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [WORDS*WIDTH-1:0] cfg_in,
    output logic [WORDS*WIDTH-1:0] cfg_q,
    output logic                   we_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            we_q  <= 1'b0;
        end else begin
            we_q <= load;
            if (load) begin
                cfg_q <= cfg_in;
            end
        end
    end

endmodule

// File: rtl/pack_cfg_gen.sv
module pack_cfg_gen
    import pack_cfg_pkg::*;
#(
    parameter int BW = BPW_W,
    parameter int WW = WPE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BW-1:0]     bits_per_word,
    input  logic [WW-1:0]     words_per_entry,
    input  logic              msb_first,
    input  logic              tx_sel,
    input  logic              rx_sel,
    output logic              done,
    output logic              invalid,
    output logic              tx_we,
    output logic              rx_we,
    output logic              gran_we,
    output logic [CFG_W-1:0]  tx_cfg0,
    output logic [CFG_W-1:0]  tx_cfg1,
    output logic [CFG_W-1:0]  rx_cfg0,
    output logic [CFG_W-1:0]  rx_cfg1,
    output logic [GRAN_W-1:0] gran_code
);

    localparam int BPB_W = BW - 2;
    localparam int CNT_W = BPB_W + WW;
    localparam int BANK_BITS = NUM_CFG * CFG_W;

    logic [BPB_W-1:0]     bytes_per_word;
    logic [CNT_W-1:0]     vec_count;
    geom_t                geom;
    slice_t               slices [NUM_VEC];
    logic [BANK_BITS-1:0] next_cfg;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [BANK_BITS-1:0] bank_cfg [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_we;

    logic  done_q;
    logic  invalid_q;
    logic  gran_we_q;
    gran_e gran_q;

    pack_geom #(
        .BW (BW),
        .WW (WW)
    ) u_geom (
        .bpw            (bits_per_word),
        .wpe            (words_per_entry),
        .bytes_per_word (bytes_per_word),
        .vec_count      (vec_count),
        .geom           (geom)
    );

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_slice
        pack_slice #(
            .IDX   (i),
            .BW    (BW),
            .BPB_W (BPB_W),
            .CNT_W (CNT_W)
        ) u_slice (
            .bpw            (bits_per_word),
            .bytes_per_word (bytes_per_word),
            .vec_count      (vec_count),
            .msb_first      (msb_first),
            .slice          (slices[i])
        );
    end

    for (genvar p = 0; p < NUM_CFG; p++) begin : g_pair
        assign next_cfg[p*CFG_W +: CFG_W] = join_pair(slices[2*p], slices[2*p+1]);
    end

    assign bank_sel = {rx_sel, tx_sel};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pack_bank #(
            .WORDS (NUM_CFG),
            .WIDTH (CFG_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .load   (start && geom.valid && bank_sel[b]),
            .cfg_in (next_cfg),
            .cfg_q  (bank_cfg[b]),
            .we_q   (bank_we[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            invalid_q <= 1'b0;
            gran_we_q <= 1'b0;
            gran_q    <= GRAN_LANES8;
        end else begin
            done_q    <= start;
            gran_we_q <= start && geom.gran_ok;
            if (start) begin
                invalid_q <= !geom.valid;
            end
            if (start && geom.gran_ok) begin
                gran_q <= geom.gran;
            end
        end
    end

    assign done      = done_q;
    assign invalid   = invalid_q;
    assign gran_we   = gran_we_q;
    assign gran_code = gran_q;
    assign tx_we     = bank_we[0];
    assign rx_we     = bank_we[1];
    assign tx_cfg0   = bank_cfg[0][CFG_W-1:0];
    assign tx_cfg1   = bank_cfg[0][2*CFG_W-1:CFG_W];
    assign rx_cfg0   = bank_cfg[1][CFG_W-1:0];
    assign rx_cfg1   = bank_cfg[1][2*CFG_W-1:CFG_W];

endmodule

// File: rtl/pack_cfg_gen_chk.sv
module pack_cfg_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic        invalid,
    input logic        tx_we,
    input logic        rx_we,
    input logic        gran_we,
    input logic [31:0] tx_cfg0,
    input logic [31:0] tx_cfg1,
    input logic [31:0] rx_cfg0,
    input logic [31:0] rx_cfg1,
    input logic [1:0]  gran_code
);

    p_done_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_needs_start_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    p_we_inside_done_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_we || rx_we || gran_we) |-> done);

    p_invalid_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (done && invalid) |-> !(tx_we || rx_we || gran_we));

    p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tx_we |-> ($stable(tx_cfg0) && $stable(tx_cfg1)));

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_we |-> ($stable(rx_cfg0) && $stable(rx_cfg1)));

    p_gran_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !gran_we |-> $stable(gran_code));

    p_single_stop_r5: assert property (@(posedge clk) disable iff (rst)
        tx_we |-> $onehot({tx_cfg0[0], tx_cfg0[10], tx_cfg1[0], tx_cfg1[10]}));

endmodule

bind pack_cfg_gen pack_cfg_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .invalid   (invalid),
    .tx_we     (tx_we),
    .rx_we     (rx_we),
    .gran_we   (gran_we),
    .tx_cfg0   (tx_cfg0),
    .tx_cfg1   (tx_cfg1),
    .rx_cfg0   (rx_cfg0),
    .rx_cfg1   (rx_cfg1),
    .gran_code (gran_code)
);

// File: tb/tb_pack_cfg_gen.sv
`timescale 1ns/1ps
module tb_pack_cfg_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  bits_per_word = '0;
    logic [2:0]  words_per_entry = '0;
    logic        msb_first = 1'b0;
    logic        tx_sel = 1'b0;
    logic        rx_sel = 1'b0;
    logic        done, invalid, tx_we, rx_we, gran_we;
    logic [31:0] tx_cfg0, tx_cfg1, rx_cfg0, rx_cfg1;
    logic [1:0]  gran_code;

    always #10 clk = ~clk;

    pack_cfg_gen dut (
        .clk(clk), .rst(rst), .start(start),
        .bits_per_word(bits_per_word), .words_per_entry(words_per_entry),
        .msb_first(msb_first), .tx_sel(tx_sel), .rx_sel(rx_sel),
        .done(done), .invalid(invalid), .tx_we(tx_we), .rx_we(rx_we),
        .gran_we(gran_we), .tx_cfg0(tx_cfg0), .tx_cfg1(tx_cfg1),
        .rx_cfg0(rx_cfg0), .rx_cfg1(rx_cfg1), .gran_code(gran_code)
    );

    typedef struct {
        bit          inv, txw, rxw, gw;
        logic [31:0] t0, t1, r0, r1;
        logic [1:0]  g;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [31:0] m_t0 = '0, m_t1 = '0, m_r0 = '0, m_r1 = '0;
    logic [1:0]  m_g = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model: walks the slices byte by byte as the requirements describe
    task automatic ref_calc(input int bpw, input int wpe, input bit msb,
                            output bit inv, output logic [31:0] c0, output logic [31:0] c1);
        logic [9:0] v [4];
        int n, idx, idx0, temp, len;
        n = (((bpw + 7) / 8) * 8 * wpe) / 8;
        for (int i = 0; i < 4; i++) v[i] = '0;
        inv = (n <= 0) || (n > 4);
        idx0 = msb ? bpw - 1 : 0;
        idx = idx0;
        temp = bpw;
        if (!inv) begin
            for (int i = 0; i < n; i++) begin
                len = ((temp < 8) ? temp : 8) - 1;
                v[i] = 10'((idx << 5) | (int'(msb) << 4) | (len << 1));
                if (temp <= 8) begin
                    idx = (i + 1) * 8 + idx0;
                    temp = bpw;
                end else begin
                    idx = idx + (msb ? -8 : 8);
                    temp = temp - 8;
                end
            end
            v[n-1][0] = 1'b1;
        end
        c0 = {12'b0, v[1], v[0]};
        c1 = {12'b0, v[3], v[2]};
    endtask

    task automatic run(input int bpw, input int wpe, input bit msb,
                       input bit ts, input bit rs);
        exp_t e;
        bit inv;
        logic [31:0] c0, c1;
        ref_calc(bpw, wpe, msb, inv, c0, c1);
        e.inv = inv;
        e.txw = !inv && ts;
        e.rxw = !inv && rs;
        e.gw  = !inv && (wpe != 0 || bpw == 32);
        if (e.txw) begin m_t0 = c0; m_t1 = c1; end
        if (e.rxw) begin m_r0 = c0; m_r1 = c1; end
        if (e.gw) m_g = 2'(bpw / 16);
        e.t0 = m_t0; e.t1 = m_t1; e.r0 = m_r0; e.r1 = m_r1; e.g = m_g;
        sb.push_back(e);
        @(negedge clk);
        bits_per_word = 6'(bpw);
        words_per_entry = 3'(wpe);
        msb_first = msb;
        tx_sel = ts;
        rx_sel = rs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: compare each completion with the oldest expectation
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "done without request", 32'(done), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(invalid == e.inv, "R2", "invalid", 32'(invalid), 32'(e.inv));
                    check(tx_we == e.txw, "R8", "tx_we", 32'(tx_we), 32'(e.txw));
                    check(rx_we == e.rxw, "R8", "rx_we", 32'(rx_we), 32'(e.rxw));
                    check(gran_we == e.gw, "R7", "gran_we", 32'(gran_we), 32'(e.gw));
                    check(tx_cfg0 == e.t0, "R4", "tx_cfg0", tx_cfg0, e.t0);
                    check(tx_cfg1 == e.t1, "R5", "tx_cfg1", tx_cfg1, e.t1);
                    check(rx_cfg0 == e.r0, "R6", "rx_cfg0", rx_cfg0, e.r0);
                    check(rx_cfg1 == e.r1, "R3", "rx_cfg1", rx_cfg1, e.r1);
                    check(gran_code == e.g, "R7", "gran_code", 32'(gran_code), 32'(e.g));
                end
            end else begin
                check(!(tx_we || rx_we || gran_we), "R9", "strobe outside done",
                      32'({tx_we, rx_we, gran_we}), 32'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check({done, invalid, tx_we, rx_we, gran_we} == 5'b0, "R10", "flags", 32'({done, invalid, tx_we, rx_we, gran_we}), 32'd0);
        check(tx_cfg0 == 0 && tx_cfg1 == 0, "R10", "tx cfg", tx_cfg0 | tx_cfg1, 32'd0);
        check(rx_cfg0 == 0 && rx_cfg1 == 0, "R10", "rx cfg", rx_cfg0 | rx_cfg1, 32'd0);
        check(gran_code == 0, "R10", "gran", 32'(gran_code), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R4 R5: 24-bit slot, three slices, MSB first, literal layout
        run(23, 1, 1'b1, 1'b1, 1'b0);
        check(tx_cfg0 == 32'h00077ADE, "R1", "3-slice MSB word0", tx_cfg0, 32'h00077ADE);
        check(tx_cfg1 == 32'h000000DD, "R5", "3-slice MSB word1", tx_cfg1, 32'h000000DD);
        // R4: 7-bit words, four per entry, MSB first: starts 6,14,22,30
        run(7, 4, 1'b1, 1'b0, 1'b1);
        check(rx_cfg0 == {12'b0, 10'h1DC, 10'h0DC}, "R4", "4x7 MSB word0", rx_cfg0, {12'b0, 10'h1DC, 10'h0DC});
        check(rx_cfg1 == {12'b0, 10'h3DD, 10'h2DC}, "R4", "4x7 MSB word1", rx_cfg1, {12'b0, 10'h3DD, 10'h2DC});
        // R3: 15-bit words, two per entry, LSB first: lengths 7,6,7,6
        run(15, 2, 1'b0, 1'b1, 1'b1);
        check(tx_cfg0 == {12'b0, 10'h10C, 10'h00E}, "R3", "2x15 LSB word0", tx_cfg0, {12'b0, 10'h10C, 10'h00E});
        check(rx_cfg1 == {12'b0, 10'h30D, 10'h20E}, "R3", "2x15 LSB word1", rx_cfg1, {12'b0, 10'h30D, 10'h20E});
        // R2: zero and oversize counts
        run(32, 0, 1'b0, 1'b1, 1'b1);
        run(8, 5, 1'b1, 1'b1, 1'b1);
        run(0, 3, 1'b0, 1'b1, 1'b1);
        check(tx_cfg0 == {12'b0, 10'h10C, 10'h00E}, "R2", "tx held after invalid", tx_cfg0, {12'b0, 10'h10C, 10'h00E});
        // R7: single 32-bit lane
        run(32, 1, 1'b0, 1'b1, 1'b0);
        check(gran_code == 2'd2, "R7", "32-bit lane code", 32'(gran_code), 32'd2);
        // R8: neither bank selected
        run(16, 2, 1'b1, 1'b0, 1'b0);

        // sweep all legal geometries and bank selects
        for (int b = 1; b <= 32; b++) begin
            for (int w = 0; w <= 5; w++) begin
                for (int m = 0; m < 2; m++) begin
                    int k = b * 12 + w * 2 + m;
                    run(b, w, m[0], k[0] | k[2], k[1]);
                end
            end
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "pending completions", 32'(sb.size()), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule